// File: doc/BRIEF.md
# Scanline Prefetch Line Buffer with 2x2 Pixel Doubling

The block turns a quarter-resolution framebuffer held in an external byte-wide SRAM into a full-resolution pixel-index stream. The source image is 320x240 at 2 bits per pixel, and the display is 640x480. Each byte in SRAM packs four pixels, so one source row is 80 bytes. An external sync generator supplies the horizontal and vertical raster counters. The block drives a 2-bit palette index, which is passed on to a palette and DAC.

Fetches happen only in horizontal blanking. In the blanking interval that comes before an even display line, the fetch engine reads the next source row from SRAM, one byte per clock, into a small single-ported line buffer. During active video the buffer is read back at the same address port. A 4:1 selector picks the current pixel pair, most significant pair first. Each pixel is held for two dot clocks. The odd display line that follows replays the same buffer contents, so the SRAM bus stays idle during all active video and during every blanking interval that comes before an odd line.

Top module: `scanline_prefetcher`

## Requirements
- R1: One clock after the counters present active position (h, v), pix_idx equals source pixel (h/2, v/2). The pixel is bits [7-2k : 6-2k] of SRAM byte (v/2)*BYTES + (h/2)/4, with k = (h/2) mod 4, so the most significant pair comes first. BYTES is H_ACTIVE/8 (80 by default).
- R2: Within active video, the output for each odd h equals the output for the even h just before it.
- R3: Display line 2n+1 shows exactly the same pixels as display line 2n.
- R4: sram_rd is never high while h < H_ACTIVE and v < V_ACTIVE.
- R5: A fetch happens only on a line whose successor line L is even and below V_ACTIVE. The successor of V_TOTAL-1 is 0. A fetch is exactly BYTES reads. Every other line issues no read at all.
- R6: During a fetch, sram_rd is high for h = H_ACTIVE .. H_ACTIVE+BYTES-1, with sram_addr = (L/2)*BYTES + (h - H_ACTIVE). The address rises by one each clock. sram_data is taken one clock after its address.
- R7: One clock after the counters present a position outside the active area, pix_idx is 0.
- R8: While rst_n is low, pix_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_cnt | input | HW | Horizontal raster position, 0..H_TOTAL-1 |
| v_cnt | input | VW | Vertical raster position, 0..V_TOTAL-1 |
| sram_addr | output | SRAM_AW | SRAM byte address |
| sram_rd | output | 1 | SRAM read strobe |
| sram_data | input | 8 | SRAM read data, valid one clock after the address |
| pix_idx | output | 2 | Palette index of the current display pixel |

## Verification
On every clock, the assertions check four things: no read in active video, reads only before even lines, consecutive read addresses that step by one, and a zero index after a blanking position. They also check that each pixel is repeated for two dot clocks. Correct unpacking order, the source-row address arithmetic and vertical line repetition need knowledge of the SRAM contents. Only the bench's full-frame sweep can show these, by comparing every pixel against a pattern computed from the address. The bench also counts the reads on each line.

// File: rtl/lbuf_pkg.sv
// Package: shared pixel and byte types for the scanline prefetcher.
// Assumes the pixel width divides the SRAM byte width exactly.
package lbuf_pkg;
    localparam int PIX_W        = 2;
    localparam int BYTE_W       = 8;
    localparam int PIX_PER_BYTE = BYTE_W / PIX_W;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/lbuf_fetch.sv
// Fetch engine: decides from the raster counters whether the coming line is
// even. If it is, the engine issues BYTES consecutive SRAM reads at the start
// of horizontal blanking. It delays the strobe and byte index by one clock so
// that they line up with the returning data.
// Assumes: H_TOTAL - H_ACTIVE > BYTES, and SRAM read latency of one clock.
module lbuf_fetch #(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int HW       = 10,
    parameter int VW       = 10,
    parameter int AW       = 16,
    parameter int BYTES    = 80,
    parameter int BW       = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    output logic          rd,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [BW-1:0] wr_idx
);
    localparam logic [HW-1:0] H_ACT_C = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_END_C = HW'(H_ACTIVE + BYTES);
    localparam logic [VW-1:0] V_ACT_C = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_LST_C = VW'(V_TOTAL - 1);
    localparam logic [AW-1:0] BYTES_A = AW'(BYTES);

    logic [VW-1:0] v_next;
    logic          even_next;
    logic [HW-1:0] offs;
    logic [AW-1:0] row_a;

    // Successor line, and whether it needs a fresh source row.
    always_comb begin
        v_next    = (v_cnt == V_LST_C) ? '0 : v_cnt + VW'(1);
        even_next = (v_next < V_ACT_C) && !v_next[0];
        offs      = h_cnt - H_ACT_C;
        row_a     = AW'(v_next >> 1);
    end

    // Read window and byte address in SRAM.
    always_comb begin
        rd   = even_next && (h_cnt >= H_ACT_C) && (h_cnt < H_END_C);
        addr = row_a * BYTES_A + AW'(offs);
    end

    // Align write strobe and index with data that arrives one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            wr_idx <= '0;
        end else begin
            wr_en  <= rd;
            wr_idx <= offs[BW-1:0];
        end
    end
endmodule

// File: rtl/lbuf_store.sv
// Line store: one source row of packed bytes behind a single address port,
// plus a selector that returns one pixel of the addressed byte.
// Selector 0 gives the most significant pair.
// Assumes: the caller multiplexes the address, writing only while the buffer
// is not being shown.
module lbuf_store
    import lbuf_pkg::*;
#(
    parameter int BYTES = 80,
    parameter int BW    = 7,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [BW-1:0] addr,
    input  byte_t         wdata,
    input  logic [SW-1:0] sel,
    output pix_t          pix
);
    byte_t mem [BYTES];
    byte_t rbyte;
    pix_t  pairs [PIX_PER_BYTE];

    // Write port, used during blanking.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Asynchronous read of the addressed byte.
    always_comb rbyte = mem[addr];

    // Split the byte into pixel pairs, most significant pair first.
    for (genvar k = 0; k < PIX_PER_BYTE; k++) begin : g_pair
        always_comb pairs[k] = rbyte[BYTE_W-1-k*PIX_W -: PIX_W];
    end

    // 4:1 pixel selector.
    always_comb pix = pairs[sel];
endmodule

// File: rtl/scanline_prefetcher.sv
// Top: fetches one source row during the blanking interval before each even
// display line, then reads it back during active video. Each source pixel
// becomes a 2x2 block of display pixels. The output is registered, one clock
// behind the counters, and is forced to 0 outside the active area.
// Assumes: the counters step by one per clock and wrap at H_TOTAL / V_TOTAL.
module scanline_prefetcher
    import lbuf_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_TOTAL  = 800,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int H_SCALE  = 2,
    parameter int SRAM_AW  = 16,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(V_TOTAL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HW-1:0]      h_cnt,
    input  logic [VW-1:0]      v_cnt,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_rd,
    input  logic [7:0]         sram_data,
    output logic [1:0]         pix_idx
);
    localparam int BYTES  = H_ACTIVE / (H_SCALE * PIX_PER_BYTE);
    localparam int BW     = $clog2(BYTES);
    localparam int HS_W   = $clog2(H_SCALE);
    localparam int SW     = $clog2(PIX_PER_BYTE);
    localparam int SHIFT  = HS_W + SW;
    localparam logic [HW-1:0] H_ACT_C = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT_C = VW'(V_ACTIVE);

    logic          wr_en;
    logic [BW-1:0] wr_idx;
    logic [BW-1:0] rd_byte;
    logic [BW-1:0] buf_addr;
    logic [SW-1:0] sel;
    logic          active;
    pix_t          buf_pix;

    lbuf_fetch #(
        .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
        .HW(HW), .VW(VW), .AW(SRAM_AW), .BYTES(BYTES), .BW(BW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .rd(sram_rd), .addr(sram_addr), .wr_en(wr_en), .wr_idx(wr_idx)
    );

    // Raster decode: byte index, pixel select and active-area flag.
    always_comb begin
        rd_byte  = BW'(h_cnt >> SHIFT);
        sel      = h_cnt[HS_W +: SW];
        active   = (h_cnt < H_ACT_C) && (v_cnt < V_ACT_C);
        buf_addr = wr_en ? wr_idx : rd_byte;
    end

    lbuf_store #(.BYTES(BYTES), .BW(BW), .SW(SW)) u_store (
        .clk(clk), .wr_en(wr_en), .addr(buf_addr), .wdata(sram_data),
        .sel(sel), .pix(buf_pix)
    );

    // Registered pixel output, blanked outside the active area.
    always_ff @(posedge clk) begin
        if (!rst_n) pix_idx <= '0;
        else        pix_idx <= active ? buf_pix : '0;
    end
endmodule

// File: rtl/lbuf_checker.sv
// Checker: cycle-level properties of the prefetcher ports, bound to the top.
// Assumes the raster counters step by one per clock.
module lbuf_checker #(
    parameter int H_ACTIVE = 640,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int HW       = 10,
    parameter int VW       = 10,
    parameter int AW       = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          sram_rd,
    input logic [AW-1:0] sram_addr,
    input logic [1:0]    pix_idx
);
    localparam logic [HW-1:0] H_ACT_C = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT_C = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_LST_C = VW'(V_TOTAL - 1);

    logic          armed, armed2, in_act;
    logic [VW-1:0] nxt;

    // History-valid flags: one and two clocks out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            armed  <= 1'b1;
            armed2 <= armed;
        end
    end

    // Independent view of the active area and of the next line.
    always_comb begin
        in_act = (h_cnt < H_ACT_C) && (v_cnt < V_ACT_C);
        nxt    = (v_cnt == V_LST_C) ? '0 : v_cnt + VW'(1);
    end

    AST_NO_ACTIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rd |-> !in_act); // R4
    AST_EVEN_FETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sram_rd |-> (!nxt[0] && nxt < V_ACT_C)); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sram_rd && $past(sram_rd)) |-> sram_addr == $past(sram_addr) + AW'(1)); // R6
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!in_act)) |-> pix_idx == 2'b00); // R7
    AST_PIX_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed2 && $past(in_act) && $past(h_cnt[0]) &&
         $past(h_cnt) == $past(h_cnt, 2) + HW'(1) && $past(v_cnt) == $past(v_cnt, 2))
        |-> pix_idx == $past(pix_idx)); // R2
endmodule

bind scanline_prefetcher lbuf_checker #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
    .HW(HW), .VW(VW), .AW(SRAM_AW)
) u_lbuf_checker (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .sram_rd(sram_rd), .sram_addr(sram_addr), .pix_idx(pix_idx)
);

// File: tb/scanline_prefetcher_bench.sv
// Bench: small raster, two full frames. Every output pixel and every SRAM
// strobe is compared against values computed from the doubling rule.
module scanline_prefetcher_bench;
    localparam int HA = 64, HT = 96, VA = 16, VT = 20, AW = 16;
    localparam int HW = $clog2(HT), VW = $clog2(VT);
    localparam int B  = HA / 8;
    localparam int MEMN = B * (VA / 2);

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [HW-1:0] h = '0;
    logic [VW-1:0] v = VW'(VT - 1);
    logic [AW-1:0] sram_addr;
    logic          sram_rd;
    logic [7:0]    sram_q = '0;
    logic [1:0]    pix;
    int compared = 0, mismatched = 0, reads = 0;
    int last_h = 0, last_v = VT - 1;
    bit done = 0;

    always #10 clk = ~clk;

    scanline_prefetcher #(.H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_TOTAL(VT),
        .SRAM_AW(AW)) u_scanline_prefetcher (
        .clk(clk), .rst_n(rst_n), .h_cnt(h), .v_cnt(v), .sram_addr(sram_addr),
        .sram_rd(sram_rd), .sram_data(sram_q), .pix_idx(pix));

    function automatic logic [7:0] pat(int a);
        return 8'((a * 73 + 29) ^ (a >> 3));
    endfunction

    function automatic int exp_pix(int hh, int vv);
        int k;
        if (hh >= HA || vv >= VA) return 0;
        k = (hh / 2) % 4;
        return int'((pat((vv / 2) * B + hh / 8) >> (6 - 2 * k)) & 8'h3);
    endfunction

    // SRAM model: data one clock after the address.
    always @(posedge clk) if (sram_rd) sram_q <= pat(int'(sram_addr));

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", req, h, v, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R8", int'(pix), 0);
        end
        rst_n = 1'b1;
        for (int c = 0; c < 2 * HT * VT + HT; c++) begin
            @(posedge clk);
            h <= (h == HW'(HT - 1)) ? '0 : h + HW'(1);
            if (h == HW'(HT - 1)) v <= (v == VW'(VT - 1)) ? '0 : v + VW'(1);
            @(negedge clk);
            begin
                int hh, vv, nx, er, ea;
                hh = int'(h); vv = int'(v);
                nx = (vv == VT - 1) ? 0 : vv + 1;
                // R1 / R3 / R7: pixel from the previous counter position.
                if (last_h < HA && last_v < VA)
                    chk((last_v % 2) ? "R3" : "R1", int'(pix), exp_pix(last_h, last_v));
                else
                    chk("R7", int'(pix), 0);
                // R4 / R6: read strobe and address.
                er = (nx < VA && nx % 2 == 0 && hh >= HA && hh < HA + B) ? 1 : 0;
                chk((hh < HA && vv < VA) ? "R4" : "R6", int'(sram_rd), er);
                if (er == 1) begin
                    ea = (nx / 2) * B + (hh - HA);
                    chk("R6", int'(sram_addr), ea);
                    if (ea >= MEMN) chk("R6", ea, MEMN - 1);
                end
                if (sram_rd) reads++;
                // R5: reads per line.
                if (hh == HT - 1) begin
                    chk("R5", reads, (nx < VA && nx % 2 == 0) ? B : 0);
                    reads = 0;
                end
                last_h = hh; last_v = vv;
            end
        end
        done = 1;
    end

    initial begin
        for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
        if (!done) begin
            compared++; mismatched++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule